// File: doc/BRIEF.md
# Dual Match Timer

This block holds two independent 32-bit up-counters. Each counter has its own clock divider, a control word, a count register that software can load and a compare value. When a running counter steps onto its compare value, that timer's bit in a shared pending register is set. The bit raises that timer's interrupt line if the timer's interrupt output is enabled. The counter keeps running and wraps through zero, so the next match comes one full period later unless software reprograms the timer.

Software reaches the block through a plain 32-bit register port: address, write strobe, write data and combinational read data. A one-shot event works like this. Software loads the count with zero, writes the distance to the event into the compare register and then enables the timer. The interrupt handler clears the pending bit and turns the timer off.

Top module: `dual_match_timer`

## Requirements
- R1: The register offsets are: control at 0x00 and 0x04, compare at 0x18 and 0x1C, count at 0x48 and 0x4C (timer 0 first, then timer 1), pending at 0x60. Control reads back its divider in bits [31:16] and its three enable bits in [2:0], with bits [15:3] as zero. Compare and count read back what was written. Any other offset reads zero.
- R2: Control bit 0 (run) lets the counter advance. With run clear, the count holds its value.
- R3: With divider value N in control bits [31:16], a running counter advances by one every N+1 clocks. The first step comes N+1 clocks after the control write.
- R4: Every write to a control register restarts the divider phase, and no step happens on the cycle of that write.
- R5: A write to a count register loads the value directly. It takes priority over a step in the same cycle, and the counter continues from the loaded value.
- R6: When a running counter with control bit 1 (match enable) steps onto its compare value, that timer's pending bit is set. The counter keeps running and wraps from 0xFFFFFFFF to 0. With bit 1 clear, no pending bit is set.
- R7: Pending bit i (bit 0 for timer 0, bit 1 for timer 1) stays set until software writes a one to that bit at 0x60. Zeros written there have no effect. A match in the same cycle as the clear wins.
- R8: Interrupt line i is high exactly when pending bit i is set and control bit 2 (interrupt enable) of timer i is set.
- R9: After reset every register reads zero and both interrupt lines are low.
- R10: The two timers are independent: programming or clearing one does not change the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the block and the input to both dividers |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Byte offset of the register being accessed |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| timer_irq | output | 2 | Interrupt line per timer, bit i for timer i |

## Verification
The checker watches these on every cycle: a stopped counter never moves, a running counter never moves by more than one, a match always leaves its pending bit set, a write-one clear with no competing match empties the bit, a pending bit never drops without a clear, and no interrupt line is high without its pending bit. Several behaviours depend on exact cycle counts and can only be seen in the bench's scenarios. These are the divider period, the phase restart on a control write, a load beating a step, the set-over-clear priority, the wrap onto a compare value of zero, and register readback with reserved bits masked.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int PRESC_W = 16;

    localparam logic [ADDR_W-1:0] CTRL_BASE   = 8'h00;
    localparam logic [ADDR_W-1:0] CMP_BASE    = 8'h18;
    localparam logic [ADDR_W-1:0] COUNT_BASE  = 8'h48;
    localparam logic [ADDR_W-1:0] PENDING_OFF = 8'h60;

    // Control fields kept in flops; the rest of the word reads as zero.
    typedef struct packed {
        logic [PRESC_W-1:0] div;
        logic               irq_en;
        logic               match_en;
        logic               run;
    } ctl_t;

    typedef struct packed {
        ctl_t              ctl;
        logic [DATA_W-1:0] cmp;
        logic [DATA_W-1:0] count;
    } chan_t;

    function automatic logic [ADDR_W-1:0] ctrl_addr(input int i);
        return CTRL_BASE + ADDR_W'(4 * i);
    endfunction

    function automatic logic [ADDR_W-1:0] cmp_addr(input int i);
        return CMP_BASE + ADDR_W'(4 * i);
    endfunction

    function automatic logic [ADDR_W-1:0] count_addr(input int i);
        return COUNT_BASE + ADDR_W'(4 * i);
    endfunction

    function automatic logic [DATA_W-1:0] ctl_word(input ctl_t c);
        return {c.div, {(DATA_W - PRESC_W - 3){1'b0}}, c.irq_en, c.match_en, c.run};
    endfunction

endpackage

// File: rtl/dmt_prescaler.sv
module dmt_prescaler #(
    parameter int PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               restart,
    input  logic [PRESC_W-1:0] div,
    output logic               tick
);
    logic [PRESC_W-1:0] phase_d, phase_q;

    always_comb begin
        tick    = enable && !restart && (phase_q == div);
        phase_d = phase_q;
        if (restart || !enable || tick) begin
            phase_d = '0;
        end else begin
            phase_d = phase_q + PRESC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end
endmodule

// File: rtl/dmt_channel.sv
module dmt_channel
    import dmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              cmp_we,
    input  logic              count_we,
    input  logic [DATA_W-1:0] wdata,
    output ctl_t              ctl_o,
    output logic [DATA_W-1:0] cmp_o,
    output logic [DATA_W-1:0] count_o,
    output logic              hit_o
);
    chan_t             ch_d, ch_q;
    logic              step;
    logic [DATA_W-1:0] count_inc;
    logic              unused_wdata;

    assign unused_wdata = ^wdata[PRESC_W-1:3];

    dmt_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (ch_q.ctl.run),
        .restart(ctl_we),
        .div    (ch_q.ctl.div),
        .tick   (step)
    );

    assign count_inc = ch_q.count + DATA_W'(1);

    always_comb begin
        ch_d  = ch_q;
        hit_o = step && !count_we && ch_q.ctl.match_en && (count_inc == ch_q.cmp);
        if (ctl_we) begin
            ch_d.ctl.div      = wdata[DATA_W-1:DATA_W-PRESC_W];
            ch_d.ctl.irq_en   = wdata[2];
            ch_d.ctl.match_en = wdata[1];
            ch_d.ctl.run      = wdata[0];
        end
        if (cmp_we) ch_d.cmp = wdata;
        if (count_we)  ch_d.count = wdata;
        else if (step) ch_d.count = count_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign ctl_o   = ch_q.ctl;
    assign cmp_o   = ch_q.cmp;
    assign count_o = ch_q.count;
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
    import dmt_pkg::*;
#(
    parameter int NUM_TIMERS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NUM_TIMERS-1:0] timer_irq
);
    localparam int IDX_W = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1;

    ctl_t [NUM_TIMERS-1:0]             ctl_w;
    logic [NUM_TIMERS-1:0][DATA_W-1:0] cmp_w;
    logic [NUM_TIMERS-1:0][DATA_W-1:0] cnt_w;
    logic [NUM_TIMERS-1:0]             hit_w;
    logic [NUM_TIMERS-1:0]             run_w;
    logic [NUM_TIMERS-1:0]             ien_w;
    logic [NUM_TIMERS-1:0]             pend_d, pend_q;
    logic [NUM_TIMERS-1:0]             clr_mask;
    logic [IDX_W-1:0]                  unused_idx;

    assign unused_idx = '0;

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
        dmt_channel u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl_we  (reg_we && (reg_addr == ctrl_addr(g))),
            .cmp_we  (reg_we && (reg_addr == cmp_addr(g))),
            .count_we(reg_we && (reg_addr == count_addr(g))),
            .wdata   (reg_wdata),
            .ctl_o   (ctl_w[g]),
            .cmp_o   (cmp_w[g]),
            .count_o (cnt_w[g]),
            .hit_o   (hit_w[g])
        );
        assign run_w[g] = ctl_w[g].run;
        assign ien_w[g] = ctl_w[g].irq_en;
    end

    // Pending bits: a match in the same cycle outranks a clear.
    always_comb begin
        clr_mask = (reg_we && (reg_addr == PENDING_OFF)) ? reg_wdata[NUM_TIMERS-1:0] : '0;
        pend_d   = (pend_q & ~clr_mask) | hit_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign timer_irq = pend_q & ien_w;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == PENDING_OFF) reg_rdata = DATA_W'(pend_q);
        for (int i = 0; i < NUM_TIMERS; i++) begin
            if (reg_addr == ctrl_addr(i))  reg_rdata = ctl_word(ctl_w[i]);
            if (reg_addr == cmp_addr(i))   reg_rdata = cmp_w[i];
            if (reg_addr == count_addr(i)) reg_rdata = cnt_w[i];
        end
    end
endmodule

// File: rtl/dmt_checker.sv
module dmt_checker
    import dmt_pkg::*;
#(
    parameter int NUM_TIMERS = 2
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [7:0]                       reg_addr,
    input logic                             reg_we,
    input logic [31:0]                      reg_wdata,
    input logic [NUM_TIMERS-1:0]            timer_irq,
    input logic [NUM_TIMERS-1:0][DATA_W-1:0] cnt,
    input logic [NUM_TIMERS-1:0]            run,
    input logic [NUM_TIMERS-1:0]            hit,
    input logic [NUM_TIMERS-1:0]            pend
);
    logic unused_hi;
    assign unused_hi = ^reg_wdata[31:NUM_TIMERS];

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chk
        logic cnt_wr, pend_clr;
        assign cnt_wr   = reg_we && (reg_addr == count_addr(g));
        assign pend_clr = reg_we && (reg_addr == PENDING_OFF) && reg_wdata[g];

        assert_stopped_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[g] && !cnt_wr) |=> (cnt[g] == $past(cnt[g])));

        assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (run[g] && !cnt_wr) |=>
                ((cnt[g] == $past(cnt[g])) || (cnt[g] == $past(cnt[g]) + 32'd1)));

        assert_match_pends_R6: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> pend[g]);

        assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_clr && !hit[g]) |=> !pend[g]);

        assert_pending_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[g] && !pend_clr) |=> pend[g]);

        assert_irq_needs_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
            timer_irq[g] |-> pend[g]);
    end
endmodule

bind dual_match_timer dmt_checker #(.NUM_TIMERS(NUM_TIMERS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .reg_wdata(reg_wdata),
    .timer_irq(timer_irq),
    .cnt      (cnt_w),
    .run      (run_w),
    .hit      (hit_w),
    .pend     (pend_q)
);

// File: tb/sim_dual_match_timer.sv
`timescale 1ns/1ps
module sim_dual_match_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  timer_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    localparam logic [7:0] A_CTL0 = 8'h00, A_CTL1 = 8'h04;
    localparam logic [7:0] A_CMP0 = 8'h18, A_CMP1 = 8'h1C;
    localparam logic [7:0] A_CNT0 = 8'h48, A_CNT1 = 8'h4C;
    localparam logic [7:0] A_PEND = 8'h60;

    always #10 clk = ~clk;

    dual_match_timer u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .timer_irq(timer_irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTL0, v); chk("R9 ctl0", v, 0);
        rd(A_CMP1, v); chk("R9 cmp1", v, 0);
        rd(A_CNT0, v); chk("R9 cnt0", v, 0);
        rd(A_PEND, v); chk("R9 pending", v, 0);
        chk("R9 irq", {30'b0, timer_irq}, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        wr(A_CTL1, 32'hABCD_FFF8);
        rd(A_CTL1, v); chk("R1 ctl reserved", v, 32'hABCD_0000);
        wr(A_CMP1, 32'h1234_5678);
        rd(A_CMP1, v); chk("R1 cmp1", v, 32'h1234_5678);
        wr(A_CNT1, 32'h0000_DEAD);
        rd(A_CNT1, v); chk("R1 cnt1", v, 32'h0000_DEAD);
        rd(8'h08, v);  chk("R1 undefined", v, 0);
        rd(A_CMP0, v); chk("R10 cmp0 untouched", v, 0);
        wr(A_CTL1, 0); wr(A_CMP1, 0); wr(A_CNT1, 0);
    endtask

    task automatic t_run_stop();
        logic [31:0] v;
        wr(A_CNT0, 0); wr(A_CTL0, 32'h1);
        cyc(10); rd(A_CNT0, v); chk("R2 running", v, 10);
        wr(A_CTL0, 0);
        rd(A_CNT0, v); chk("R4 no step on ctl write", v, 10);
        cyc(7); rd(A_CNT0, v); chk("R2 stopped holds", v, 10);
    endtask

    task automatic t_divider();
        logic [31:0] v;
        wr(A_CNT0, 0); wr(A_CTL0, 32'h0003_0001);
        cyc(11); rd(A_CNT0, v); chk("R3 div3 at 11", v, 2);
        cyc(1);  rd(A_CNT0, v); chk("R3 div3 at 12", v, 3);
        cyc(3);  rd(A_CNT0, v); chk("R3 before phase restart", v, 3);
        wr(A_CTL0, 32'h0003_0001);
        rd(A_CNT0, v); chk("R4 step suppressed", v, 3);
        cyc(3); rd(A_CNT0, v); chk("R4 phase restarted", v, 3);
        cyc(1); rd(A_CNT0, v); chk("R4 first step after restart", v, 4);
        wr(A_CTL0, 0);
    endtask

    task automatic t_load();
        logic [31:0] v;
        wr(A_CTL0, 32'h1);
        wr(A_CNT0, 100);
        rd(A_CNT0, v); chk("R5 load wins", v, 100);
        cyc(1); rd(A_CNT0, v); chk("R5 continues", v, 101);
        wr(A_CTL0, 0);
    endtask

    task automatic t_match();
        logic [31:0] v;
        wr(A_PEND, 32'hFFFF);
        wr(A_CNT0, 0); wr(A_CMP0, 5); wr(A_CTL0, 32'h7);
        cyc(4); rd(A_PEND, v); chk("R6 not yet", v, 0);
        chk("R8 irq low before", {30'b0, timer_irq}, 0);
        cyc(1); rd(A_PEND, v); chk("R6 match sets", v, 1);
        chk("R8 irq0 high", {30'b0, timer_irq}, 1);
        rd(A_CNT0, v); chk("R6 count at match", v, 5);
        cyc(3); rd(A_CNT0, v); chk("R6 keeps running", v, 8);
        rd(A_PEND, v); chk("R7 sticky", v, 1);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(A_CNT1, 0); wr(A_CMP1, 2); wr(A_CTL1, 32'h7);
        cyc(2); rd(A_PEND, v); chk("R10 both pending", v, 3);
        wr(A_PEND, 32'h1);
        rd(A_PEND, v); chk("R7 clear bit0 only", v, 2);
        chk("R10 irq1 kept", {30'b0, timer_irq}, 2);
        wr(A_PEND, 32'h0);
        rd(A_PEND, v); chk("R7 zero write ignored", v, 2);
        wr(A_PEND, 32'hFFFF);
        rd(A_PEND, v); chk("R7 clear all", v, 0);
        wr(A_CTL0, 0); wr(A_CTL1, 0);
    endtask

    task automatic t_gating();
        logic [31:0] v;
        wr(A_CNT0, 0); wr(A_CMP0, 2); wr(A_CTL0, 32'h3);
        cyc(2); rd(A_PEND, v); chk("R6 pending with irq off", v, 1);
        chk("R8 irq masked", {30'b0, timer_irq}, 0);
        wr(A_CTL0, 32'h7);
        chk("R8 irq unmasked", {30'b0, timer_irq}, 1);
        wr(A_CTL0, 0); wr(A_PEND, 32'h1);
        wr(A_CNT0, 0); wr(A_CMP0, 2); wr(A_CTL0, 32'h5);
        cyc(3); rd(A_CNT0, v); chk("R6 counts without match enable", v, 3);
        rd(A_PEND, v); chk("R6 no pending without match enable", v, 0);
        wr(A_CTL0, 0);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        wr(A_CNT0, 32'hFFFF_FFFE); wr(A_CMP0, 0); wr(A_CTL0, 32'h3);
        cyc(1); rd(A_CNT0, v); chk("R6 before wrap", v, 32'hFFFF_FFFF);
        rd(A_PEND, v); chk("R6 no early match", v, 0);
        cyc(1); rd(A_CNT0, v); chk("R6 wrapped", v, 0);
        rd(A_PEND, v); chk("R6 match at zero", v, 1);
        wr(A_CTL0, 0); wr(A_PEND, 32'h3);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        wr(A_CNT0, 0); wr(A_CMP0, 1); wr(A_CTL0, 32'h3);
        wr(A_PEND, 32'h1);
        rd(A_PEND, v); chk("R7 set beats clear", v, 1);
        wr(A_CTL0, 0); wr(A_PEND, 32'h1);
        rd(A_PEND, v); chk("R7 later clear", v, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_run_stop();
        t_divider();
        t_load();
        t_match();
        t_clear();
        t_gating();
        t_wrap();
        t_set_wins();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule